// File: doc/BRIEF.md
# Producer-Consumer Latency Scoreboard

This block keeps one entry for each of 32 integer registers. Each entry records the class of the instruction that last wrote the register. That class includes the unit it ran on, where this matters. The entry also holds a countdown that shows how many cycles have passed since that producer issued. A new producer is recorded through one write port per cycle.

Each cycle the issue logic presents up to two source operands of a candidate instruction. Each operand carries a use tag: execute operand, memory address or store data. The block answers for each operand whether the value may be consumed this cycle. It also raises a stall when any operand is not yet usable. The required distance depends on the pair of producer and use, not on the producer alone. For example, a load feeding an address must wait longer than a load feeding store data.

A producer that issues in cycle c makes its register usable in cycle c+k exactly when k is at least the distance for that pair. A check made in cycle c itself still sees the entry as it was before that write.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset every register reports ready for every use.
- R2: A load producer (kind 1) needs 3 cycles before its result is used as an address (use 1), 0 cycles before use as store data (use 2), and 1 cycle before use as an execute operand (use 0).
- R3: A simple ALU producer (kind 0) issued with the load/store unit flag set needs 1 cycle before use as an address (use 1) and 0 cycles before any other use.
- R4: An ALU producer (kind 0) issued with the unit flag clear, and a HI/LO move (kind 7), both need 5 cycles before use as an address (use 1) and 1 cycle before any other use.
- R5: A multiply producer (kind 2) needs 7 cycles before use as an address (use 1) and 3 cycles before use as an execute operand (use 0) or store data (use 2).
- R6: For any use, a move into the FP file (kind 3) needs 5 cycles, a move out of the FP file (kind 4) needs 1, FP arithmetic (kind 5) needs 4, and fused multiply-add (kind 6) needs 8.
- R7: The load/store unit flag has no effect for any kind other than kind 0.
- R8: An operand tagged as unused (use 3) always reports ready.
- R9: Register 0 always reports ready, and writes to it are ignored.
- R10: A check in the same cycle as a write to that register sees the old entry. A new write replaces the old entry completely.
- R11: The stall output is high exactly when at least one operand reports not ready.
- R12: Once the distance for a producer has passed, the register stays ready however many further cycles elapse, until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | A producer issues this cycle |
| wrReg | input | 5 | Destination register of the producer |
| wrKind | input | 3 | Producer kind code (0 ALU, 1 load, 2 multiply, 3 to-FP move, 4 from-FP move, 5 FP arithmetic, 6 fused multiply-add, 7 HI/LO move) |
| wrOnLs | input | 1 | ALU producer was issued on the load/store unit |
| rdRegFlat | input | 10 | Source register of operand p in bits [5p+4:5p] |
| rdUseFlat | input | 4 | Use tag of operand p in bits [2p+1:2p] (0 execute, 1 address, 2 store data, 3 unused) |
| rdReady | output | 2 | Operand p may be consumed this cycle |
| stall | output | 1 | At least one operand is not ready |

## Verification
Every answer is combinational from the stored entries. A producer that issues in cycle c is therefore first seen in cycle c+1, and the value of k there is 1. The bench issues a write, lets one clock edge pass, and then waits k-1 more edges before it samples at a falling edge. Each distance is probed at one cycle below its threshold and at the threshold itself. The same-cycle rule is probed before the writing edge, and again one cycle after, while a second write to that register is pending.

// File: rtl/lat_sb_pkg.sv
`timescale 1ns/1ps
package lat_sb_pkg;
  localparam int MAX_LAT = 8;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);
  localparam int CNT_W   = $clog2(MAX_LAT);
  localparam int CLS_W   = 3;
  localparam int USE_W   = 2;

  typedef enum logic [2:0] {
    K_ALU = 3'd0, K_LOAD = 3'd1, K_MUL = 3'd2, K_TOFP = 3'd3,
    K_FROMFP = 3'd4, K_FPARITH = 3'd5, K_FMA = 3'd6, K_HILO = 3'd7
  } prodKind_e;

  typedef enum logic [CLS_W-1:0] {
    C_ALU_LS, C_ALU_EX, C_LOAD, C_MUL, C_TOFP, C_FROMFP, C_FPOP, C_FMA
  } prodCls_e;

  typedef enum logic [USE_W-1:0] {
    U_EXEC = 2'd0, U_ADDR = 2'd1, U_SDATA = 2'd2, U_NONE = 2'd3
  } useKind_e;

  typedef struct packed {
    logic              we;
    prodCls_e          cls;
    logic [CNT_W-1:0]  initCnt;
  } wrStrobe_t;

  function automatic logic [LAT_W-1:0] needLat(prodCls_e c, useKind_e u);
    logic [LAT_W-1:0] n;
    case (c)
      C_ALU_LS: n = (u == U_ADDR) ? LAT_W'(1) : LAT_W'(0);
      C_ALU_EX: n = (u == U_ADDR) ? LAT_W'(5) : LAT_W'(1);
      C_LOAD:   n = (u == U_ADDR) ? LAT_W'(3) : (u == U_SDATA) ? LAT_W'(0) : LAT_W'(1);
      C_MUL:    n = (u == U_ADDR) ? LAT_W'(7) : LAT_W'(3);
      C_TOFP:   n = LAT_W'(5);
      C_FROMFP: n = LAT_W'(1);
      C_FPOP:   n = LAT_W'(4);
      C_FMA:    n = LAT_W'(8);
      default:  n = LAT_W'(MAX_LAT);
    endcase
    if (u == U_NONE) n = '0;
    return n;
  endfunction

  function automatic logic [LAT_W-1:0] worstLat(prodCls_e c);
    logic [LAT_W-1:0] w;
    case (c)
      C_ALU_LS: w = LAT_W'(1);
      C_ALU_EX: w = LAT_W'(5);
      C_LOAD:   w = LAT_W'(3);
      C_MUL:    w = LAT_W'(7);
      C_TOFP:   w = LAT_W'(5);
      C_FROMFP: w = LAT_W'(1);
      C_FPOP:   w = LAT_W'(4);
      default:  w = LAT_W'(MAX_LAT);
    endcase
    return w;
  endfunction
endpackage

// File: rtl/lat_sb_entries.sv
`timescale 1ns/1ps
module lat_sb_entries
  import lat_sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int NUM_RD   = 2,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wrStrobe_t                 strb,
  input  logic [REG_W-1:0]          wrIdx,
  input  logic [NUM_RD*REG_W-1:0]   rdRegFlat,
  output logic [NUM_RD*CLS_W-1:0]   rdClsFlat,
  output logic [NUM_RD*CNT_W-1:0]   rdCntFlat
);
  prodCls_e          clsQ [NUM_REGS];
  logic [CNT_W-1:0]  cntQ [NUM_REGS];
  logic [NUM_REGS-1:0] hit;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      hit[i] = strb.we && (wrIdx == REG_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        clsQ[i] <= C_ALU_LS;
        cntQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (hit[i]) begin
          clsQ[i] <= strb.cls;
          cntQ[i] <= strb.initCnt;
        end else if (cntQ[i] != '0) begin
          cntQ[i] <= cntQ[i] - 1'b1;
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [REG_W-1:0] idx;
    assign idx = rdRegFlat[p*REG_W +: REG_W];
    assign rdClsFlat[p*CLS_W +: CLS_W] = clsQ[idx];
    assign rdCntFlat[p*CNT_W +: CNT_W] = cntQ[idx];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    // R12: a busy entry moves one step closer to ready each cycle
    a_r12_count_down: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !$past(hit[i]) && $past(cntQ[i]) != '0)
        |-> cntQ[i] == $past(cntQ[i]) - 1'b1);
    // R12: an idle entry does not wrap back to busy
    a_r12_floor: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !$past(hit[i]) && $past(cntQ[i]) == '0) |-> cntQ[i] == '0);
  end

  // R9: the control never lets a write reach register 0
  a_r9_zero_entry: assert property (@(posedge clk) disable iff (!rstN) cntQ[0] == '0);
endmodule

// File: rtl/lat_sb_ctrl.sv
`timescale 1ns/1ps
module lat_sb_ctrl
  import lat_sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int NUM_RD   = 2,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrValid,
  input  logic [REG_W-1:0]          wrReg,
  input  logic [2:0]                wrKind,
  input  logic                      wrOnLs,
  input  logic [NUM_RD*REG_W-1:0]   rdRegFlat,
  input  logic [NUM_RD*USE_W-1:0]   rdUseFlat,
  input  logic [NUM_RD*CLS_W-1:0]   rdClsFlat,
  input  logic [NUM_RD*CNT_W-1:0]   rdCntFlat,
  output wrStrobe_t                 strb,
  output logic [REG_W-1:0]          wrIdx,
  output logic [NUM_RD-1:0]         rdReady,
  output logic                      stall
);
  prodCls_e         wrCls;
  logic [LAT_W-1:0] wrWorst;

  always_comb begin
    case (prodKind_e'(wrKind))
      K_ALU:     wrCls = wrOnLs ? C_ALU_LS : C_ALU_EX;
      K_HILO:    wrCls = C_ALU_EX;
      K_LOAD:    wrCls = C_LOAD;
      K_MUL:     wrCls = C_MUL;
      K_TOFP:    wrCls = C_TOFP;
      K_FROMFP:  wrCls = C_FROMFP;
      K_FPARITH: wrCls = C_FPOP;
      K_FMA:     wrCls = C_FMA;
      default:   wrCls = C_ALU_EX;
    endcase
    wrWorst      = worstLat(wrCls);
    strb.we      = wrValid && (wrReg != '0);
    strb.cls     = wrCls;
    strb.initCnt = CNT_W'(wrWorst - 1'b1);
  end
  assign wrIdx = wrReg;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_op
    logic [REG_W-1:0] idx;
    useKind_e         useK;
    prodCls_e         cls;
    logic [LAT_W:0]   elapsedNeed;
    logic             rdy;
    always_comb begin
      idx  = rdRegFlat[p*REG_W +: REG_W];
      useK = useKind_e'(rdUseFlat[p*USE_W +: USE_W]);
      cls  = prodCls_e'(rdClsFlat[p*CLS_W +: CLS_W]);
      elapsedNeed = {1'b0, LAT_W'(rdCntFlat[p*CNT_W +: CNT_W])} + {1'b0, needLat(cls, useK)};
      if (useK == U_NONE || idx == '0) rdy = 1'b1;
      else rdy = elapsedNeed <= {1'b0, worstLat(cls)};
    end
    assign rdReady[p] = rdy;

    // R8: an unused operand never holds issue back
    a_r8_none_ready: assert property (@(posedge clk) disable iff (!rstN)
      (rdUseFlat[p*USE_W +: USE_W] == 2'd3) |-> rdReady[p]);
    // R9: register 0 is never busy
    a_r9_zero_ready: assert property (@(posedge clk) disable iff (!rstN)
      (rdRegFlat[p*REG_W +: REG_W] == '0) |-> rdReady[p]);
  end

  assign stall = ~&rdReady;

  // R6: a fused multiply-add result is still busy one cycle after issue
  a_r6_fma_busy: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrValid) && $past(wrKind) == 3'd6 && $past(wrReg) != '0
      && rdRegFlat[REG_W-1:0] == $past(wrReg) && rdUseFlat[USE_W-1:0] != 2'd3)
      |-> !rdReady[0]);
  // R11: a stall always comes with at least one busy operand
  a_r11_stall_cause: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> $countones(rdReady) < NUM_RD);
endmodule

// File: rtl/lat_scoreboard.sv
`timescale 1ns/1ps
module lat_scoreboard
  import lat_sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int NUM_RD   = 2,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrValid,
  input  logic [REG_W-1:0]        wrReg,
  input  logic [2:0]              wrKind,
  input  logic                    wrOnLs,
  input  logic [NUM_RD*REG_W-1:0] rdRegFlat,
  input  logic [NUM_RD*2-1:0]     rdUseFlat,
  output logic [NUM_RD-1:0]       rdReady,
  output logic                    stall
);
  wrStrobe_t                strb;
  logic [REG_W-1:0]         wrIdx;
  logic [NUM_RD*CLS_W-1:0]  rdClsFlat;
  logic [NUM_RD*CNT_W-1:0]  rdCntFlat;

  lat_sb_ctrl #(.NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReg(wrReg), .wrKind(wrKind),
    .wrOnLs(wrOnLs), .rdRegFlat(rdRegFlat), .rdUseFlat(rdUseFlat),
    .rdClsFlat(rdClsFlat), .rdCntFlat(rdCntFlat), .strb(strb), .wrIdx(wrIdx),
    .rdReady(rdReady), .stall(stall)
  );

  lat_sb_entries #(.NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD)) u_entries (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .rdRegFlat(rdRegFlat),
    .rdClsFlat(rdClsFlat), .rdCntFlat(rdCntFlat)
  );
endmodule

// File: tb/lat_scoreboard_bench.sv
`timescale 1ns/1ps
module lat_scoreboard_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [4:0] wrReg = '0;
  logic [2:0] wrKind = '0;
  logic wrOnLs = 1'b0;
  logic [4:0] rd0Reg = '0, rd1Reg = '0;
  logic [1:0] rd0Use = 2'd0, rd1Use = 2'd0;
  logic [1:0] rdReady;
  logic stall;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lat_scoreboard u_lat_scoreboard (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReg(wrReg), .wrKind(wrKind),
    .wrOnLs(wrOnLs), .rdRegFlat({rd1Reg, rd0Reg}), .rdUseFlat({rd1Use, rd0Use}),
    .rdReady(rdReady), .stall(stall)
  );

  // vector: kind[10:8] onLs[7] use[6:5] k[4:1] expectReady[0]
  localparam int NV = 29;
  localparam logic [10:0] VEC [NV] = '{
    {3'd1,1'b0,2'd1,4'd2,1'b0}, {3'd1,1'b0,2'd1,4'd3,1'b1},   // R2 address
    {3'd1,1'b0,2'd2,4'd1,1'b1}, {3'd1,1'b0,2'd0,4'd1,1'b1},   // R2 data, execute
    {3'd0,1'b1,2'd1,4'd1,1'b1}, {3'd0,1'b1,2'd0,4'd1,1'b1},   // R3
    {3'd0,1'b1,2'd2,4'd1,1'b1},                                // R3
    {3'd0,1'b0,2'd1,4'd4,1'b0}, {3'd0,1'b0,2'd1,4'd5,1'b1},   // R4 ALU on EX
    {3'd0,1'b0,2'd0,4'd1,1'b1}, {3'd7,1'b0,2'd1,4'd4,1'b0},   // R4
    {3'd7,1'b0,2'd1,4'd5,1'b1}, {3'd7,1'b0,2'd2,4'd1,1'b1},   // R4 HI/LO move
    {3'd2,1'b0,2'd1,4'd6,1'b0}, {3'd2,1'b0,2'd1,4'd7,1'b1},   // R5 address
    {3'd2,1'b0,2'd0,4'd2,1'b0}, {3'd2,1'b0,2'd0,4'd3,1'b1},   // R5 execute
    {3'd2,1'b0,2'd2,4'd2,1'b0},                                // R5 data
    {3'd3,1'b0,2'd0,4'd4,1'b0}, {3'd3,1'b0,2'd0,4'd5,1'b1},   // R6 to-FP
    {3'd4,1'b0,2'd1,4'd1,1'b1}, {3'd5,1'b0,2'd2,4'd3,1'b0},   // R6 from-FP, arith
    {3'd5,1'b0,2'd2,4'd4,1'b1}, {3'd6,1'b0,2'd0,4'd7,1'b0},   // R6 arith, FMA
    {3'd6,1'b0,2'd1,4'd8,1'b1},                                // R6 FMA
    {3'd2,1'b1,2'd1,4'd6,1'b0}, {3'd3,1'b1,2'd0,4'd4,1'b0},   // R7 flag ignored
    {3'd5,1'b1,2'd1,4'd3,1'b0},                                // R7
    {3'd6,1'b0,2'd3,4'd1,1'b1}                                 // R8 unused operand
  };
  localparam int VREQ [NV] = '{2,2,2,2,3,3,3,4,4,4,4,4,4,5,5,5,5,5,6,6,6,6,6,6,6,7,7,7,8};

  task automatic check(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input logic [4:0] r, input logic [2:0] k, input logic ls);
    wrValid = 1'b1; wrReg = r; wrKind = k; wrOnLs = ls;
    @(posedge clk); @(negedge clk);
    wrValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: every register ready for address and store data after reset
    for (int r = 0; r < 32; r++) begin
      rd0Reg = 5'(r); rd0Use = 2'd1; rd1Reg = 5'(r); rd1Use = 2'd2;
      #0.1;
      check("R1", rdReady[0] & rdReady[1] & ~stall, 1'b1);
    end

    // table walk: operand 0 on reg 5, operand 1 on idle reg 6
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VREQ[v], v);
      rd0Reg = 5'd5; rd0Use = VEC[v][6:5]; rd1Reg = 5'd6; rd1Use = 2'd0;
      issue(5'd5, VEC[v][10:8], VEC[v][7]);
      repeat (int'(VEC[v][4:1]) - 1) @(negedge clk);
      check(tag, rdReady[0], VEC[v][0]);
      check({tag, " R11 stall"}, stall, ~VEC[v][0]);
    end

    // R9: write to register 0 ignored
    rd0Reg = 5'd0; rd0Use = 2'd1; rd1Reg = 5'd6;
    issue(5'd0, 3'd6, 1'b0);
    check("R9", rdReady[0], 1'b1);

    // R10: same-cycle check sees old entry; overwrite replaces it
    rd0Reg = 5'd7; rd0Use = 2'd1;
    wrValid = 1'b1; wrReg = 5'd7; wrKind = 3'd1; wrOnLs = 1'b0;
    #0.1;
    check("R10 old idle", rdReady[0], 1'b1);
    @(posedge clk); @(negedge clk);
    wrKind = 3'd0; wrOnLs = 1'b1;
    #0.1;
    check("R10 old load", rdReady[0], 1'b0);
    @(posedge clk); @(negedge clk);
    wrValid = 1'b0;
    check("R10 replaced", rdReady[0], 1'b1);

    // R11: stall from both operands and from one operand
    issue(5'd8, 3'd2, 1'b0);
    wrValid = 1'b1; wrReg = 5'd9; wrKind = 3'd2; wrOnLs = 1'b0;
    @(posedge clk); @(negedge clk);
    wrValid = 1'b0;
    rd0Reg = 5'd8; rd0Use = 2'd1; rd1Reg = 5'd9; rd1Use = 2'd0;
    #0.1;
    check("R11 both busy", {rdReady, stall}, 3'b001);
    rd0Reg = 5'd0;
    #0.1;
    check("R11 one busy", {rdReady, stall}, 3'b011);

    // R12: long after an FMA the register stays ready
    rd0Reg = 5'd10; rd0Use = 2'd1; rd1Reg = 5'd6;
    issue(5'd10, 3'd6, 1'b0);
    repeat (7) @(negedge clk);
    check("R12 at threshold", rdReady[0], 1'b1);
    repeat (20) @(negedge clk);
    check("R12 long after", rdReady[0], 1'b1);
    rd0Use = 2'd0;
    #0.1;
    check("R12 execute use", rdReady[0] & ~stall, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule